// File: doc/BRIEF.md
# Descriptor Auto-Reload Engine

This block services the end of a DMA transfer for a single channel at a time. Every channel keeps a four-word transfer descriptor in a control table in shared RAM. The four words are control, source address, destination address and pointer base. Next to each table sits a reload slot with the same four-word layout, and software fills that slot with the next transfer's settings ahead of time. When the data mover reports that a channel's transfer count has reached zero, the engine reads that channel's control word from RAM. If the descriptor is enabled and has auto-reload set, the engine copies the four reload words over the live table with no help from software. If reload is off, it pulses an interrupt so that a handler can reprogram the table.

The engine works out the addresses itself from a base address and a channel index. The channel's table starts at base + channel×32 and its reload slot starts 16 bytes later. All RAM traffic uses one word-wide synchronous port that carries at most one access per cycle and returns read data one cycle after the request. Data movement, bus arbitration and the advancing of source and destination addresses belong to other blocks.

Top module: `dma_reload_engine`

## Requirements
- R1: Word k (k = 0..3) of the control table of channel n is at byte address base + n×32 + 4k. The base and channel are sampled in the cycle a completion is accepted.
- R2: Word k of the reload slot of channel n is at byte address base + n×32 + 16 + 4k.
- R3: An accepted completion first reads table word 0. If bit 3 (enable) and bit 1 (auto-reload) of that word are both 1, the engine copies reload word k to table word k in the order k = 0, 1, 2, 3. Each word takes one read cycle, then one write cycle that writes the data returned by that read.
- R4: When word 3 (pointer base) is copied, bits 31:16 are taken from the reload slot and bits 15:0 are written as zero.
- R5: If bit 3 is 1 and bit 1 is 0, the engine writes nothing to RAM and raises `irq` for exactly one cycle. `irq` is high in the cycle after the control word is read, which is the third cycle after the accepting edge, counting the cycle that follows that edge as the first.
- R6: If bit 3 of the control word is 0, the completion causes no RAM write and no `irq`.
- R7: `busy` rises in the cycle after a completion is accepted. It stays high for 10 cycles when a reload is done and for 2 cycles otherwise, and it falls in the cycle after the last write.
- R8: `xfer_done` is ignored while `busy` is high. The ignored pulse causes no extra RAM access and no `irq`.
- R9: After reset, `busy`, `irq`, `mem_req` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Byte address where the per-channel tables begin |
| chan_idx | input | 3 | Channel whose count reached zero |
| xfer_done | input | 1 | One-cycle completion event from the data mover |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| busy | output | 1 | High while a completion is being serviced |
| irq | output | 1 | One-cycle interrupt when reload is not configured |

## Verification
Counting from the edge that samples `xfer_done`, `busy` is due from the next cycle onward. The control-word read is issued in that first cycle, and its outcome appears in the third cycle: either `irq` rises or the first reload read is issued. Reload writes occur in cycles 4, 6, 8 and 10, and `busy` is low again in cycle 11. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the trigger to check the length of `busy` and the exact cycle of `irq`. A monitor compares each write against a queue of expected address and data pairs, filled in issue order by the driver task, and RAM contents are compared with a bench model after every service.

// File: rtl/dre_pkg.sv
package dre_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned DESC_WORDS   = 4;
    localparam int unsigned WIDX_W       = $clog2(DESC_WORDS);
    localparam int unsigned WORD_BYTES   = DATA_W / 8;
    localparam int unsigned WORD_SHIFT   = $clog2(WORD_BYTES);
    localparam int unsigned SLOT_BYTES   = 2 * DESC_WORDS * WORD_BYTES;
    localparam int unsigned SLOT_SHIFT   = $clog2(SLOT_BYTES);
    localparam int unsigned RELOAD_OFS   = DESC_WORDS * WORD_BYTES;
    localparam int unsigned RELOAD_BIT   = 1;
    localparam int unsigned ENABLE_BIT   = 3;
    localparam int unsigned PTR_WORD     = 3;
    localparam int unsigned PTR_ZERO_LSB = 16;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [WIDX_W-1:0] widx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL_RD,
        ST_CTRL_CHK,
        ST_COPY_RD,
        ST_COPY_WR
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } mem_op_e;

    typedef enum logic {
        AREA_TABLE,
        AREA_RELOAD
    } area_e;

    typedef struct packed {
        mem_op_e op;
        area_e   area;
        widx_t   word;
    } mem_cmd_t;

    typedef enum logic [1:0] {
        ACT_SKIP,
        ACT_IRQ,
        ACT_RELOAD
    } ctrl_action_e;

    function automatic ctrl_action_e classify_ctrl(word_t ctrl);
        if (!ctrl[ENABLE_BIT])      return ACT_SKIP;
        else if (ctrl[RELOAD_BIT])  return ACT_RELOAD;
        else                        return ACT_IRQ;
    endfunction

    function automatic word_t scrub_word(widx_t w, word_t d);
        word_t r;
        r = d;
        if (w == widx_t'(PTR_WORD))
            r[PTR_ZERO_LSB-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/dre_ctx.sv
module dre_ctx
    import dre_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              busy,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CH_W-1:0]   chan_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [CH_W-1:0]   chan_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            chan_q <= '0;
        end else if (accept) begin
            base_q <= base_in;
            chan_q <= chan_in;
        end
    end

    // R1: the table location is frozen for the whole service
    assert_ctx_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !accept) |=> ($stable(base_q) && $stable(chan_q)));

endmodule

// File: rtl/dre_addr_gen.sv
module dre_addr_gen
    import dre_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CH_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CH_W-1:0]   chan,
    input  area_e             area,
    input  widx_t             word,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] AREA_OFS = ADDR_W'(RELOAD_OFS);

    logic [ADDR_W-1:0] slot_ofs;
    logic [ADDR_W-1:0] word_ofs;
    logic [ADDR_W-1:0] area_ofs;

    always_comb begin
        slot_ofs = ADDR_W'(chan) << SLOT_SHIFT;
        word_ofs = ADDR_W'(word) << WORD_SHIFT;
        area_ofs = (area == AREA_RELOAD) ? AREA_OFS : '0;
        addr     = base + slot_ofs + area_ofs + word_ofs;
    end

endmodule

// File: rtl/dre_seq.sv
module dre_seq
    import dre_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done_in,
    input  word_t    rdata,
    output logic     accept,
    output mem_cmd_t cmd,
    output logic     busy,
    output logic     irq
);

    localparam widx_t LAST_WORD = widx_t'(DESC_WORDS - 1);

    seq_state_e   state;
    widx_t        widx;
    ctrl_action_e act;

    assign accept = (state == ST_IDLE) && done_in;
    assign busy   = (state != ST_IDLE);
    assign act    = classify_ctrl(rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            widx  <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (done_in) state <= ST_CTRL_RD;
                end
                ST_CTRL_RD: begin
                    state <= ST_CTRL_CHK;
                end
                ST_CTRL_CHK: begin
                    widx <= '0;
                    unique case (act)
                        ACT_RELOAD: state <= ST_COPY_RD;
                        ACT_IRQ: begin
                            state <= ST_IDLE;
                            irq   <= 1'b1;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                ST_COPY_RD: begin
                    state <= ST_COPY_WR;
                end
                ST_COPY_WR: begin
                    if (widx == LAST_WORD) begin
                        state <= ST_IDLE;
                    end else begin
                        widx  <= widx + widx_t'(1);
                        state <= ST_COPY_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd = '{op: OP_NONE, area: AREA_TABLE, word: '0};
        unique case (state)
            ST_CTRL_RD: cmd = '{op: OP_READ,  area: AREA_TABLE,  word: '0};
            ST_COPY_RD: cmd = '{op: OP_READ,  area: AREA_RELOAD, word: widx};
            ST_COPY_WR: cmd = '{op: OP_WRITE, area: AREA_TABLE,  word: widx};
            default:    cmd = '{op: OP_NONE,  area: AREA_TABLE,  word: '0};
        endcase
    end

    // R5: the interrupt lasts one cycle only
    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R5: the interrupt is raised only after the service has finished
    assert_irq_idle_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    // R7: busy drops right after the final write
    assert_busy_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COPY_WR && widx == LAST_WORD) |=> !busy);

    // R8: a completion seen while busy starts no new service
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && done_in) |=> (state != ST_CTRL_RD));

    // R3: copy words advance strictly in ascending order
    assert_copy_order_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COPY_WR && widx != LAST_WORD) |=>
            (state == ST_COPY_RD && widx == $past(widx) + widx_t'(1)));

endmodule

// File: rtl/dre_mem_if.sv
module dre_mem_if
    import dre_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  mem_cmd_t          cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  word_t             rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_wdata
);

    always_comb begin
        mem_req   = (cmd.op != OP_NONE);
        mem_we    = (cmd.op == OP_WRITE);
        mem_addr  = mem_req ? addr_in : '0;
        mem_wdata = mem_we ? scrub_word(cmd.word, rdata) : '0;
    end

endmodule

// File: rtl/dma_reload_engine.sv
module dma_reload_engine
    import dre_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic              xfer_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              irq
);

    logic              accept;
    mem_cmd_t          cmd;
    logic [ADDR_W-1:0] base_q;
    logic [CH_W-1:0]   chan_q;
    logic [ADDR_W-1:0] calc_addr;

    dre_seq i_seq (
        .clk     (clk),
        .rst     (rst),
        .done_in (xfer_done),
        .rdata   (mem_rdata),
        .accept  (accept),
        .cmd     (cmd),
        .busy    (busy),
        .irq     (irq)
    );

    dre_ctx #(.ADDR_W(ADDR_W), .CH_W(CH_W)) i_ctx (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .busy    (busy),
        .base_in (base_addr),
        .chan_in (chan_idx),
        .base_q  (base_q),
        .chan_q  (chan_q)
    );

    dre_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W)) i_addr (
        .base (base_q),
        .chan (chan_q),
        .area (cmd.area),
        .word (cmd.word),
        .addr (calc_addr)
    );

    dre_mem_if #(.ADDR_W(ADDR_W)) i_mem (
        .cmd       (cmd),
        .addr_in   (calc_addr),
        .rdata     (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R3: every write lands on the table word just below the slot word read one cycle earlier
    assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_req) && !$past(mem_we) &&
                    mem_addr == $past(mem_addr) - ADDR_W'(RELOAD_OFS)));

    // R6: RAM is written only during a service
    assert_wr_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R9: no RAM traffic while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

endmodule

// File: tb/test_dma_reload_engine.sv
module test_dma_reload_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_addr = BASE;
    logic [2:0]  chan_idx = '0;
    logic        xfer_done = 1'b0;
    logic        mem_req, mem_we, busy, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] ram [128];
    logic [31:0] model [128];
    logic [63:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_reload_engine i_dma_reload_engine (
        .clk       (clk),
        .rst       (rst),
        .base_addr (base_addr),
        .chan_idx  (chan_idx),
        .xfer_done (xfer_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .irq       (irq)
    );

    function automatic int widx(logic [31:0] a);
        return int'(a[8:2]);
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we)  ram[widx(mem_addr)] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= ram[widx(mem_addr)];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare each write with the scoreboard queue (R1 R3 R4)
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R3 write order/addr/data",
                      {mem_addr, mem_wdata}, e);
            end
        end
    end

    function automatic logic [31:0] tab_addr(int ch, int k);
        return BASE + 32'(ch * 32 + 4 * k);
    endfunction

    task automatic put(logic [31:0] a, logic [31:0] d);
        ram[widx(a)]   = d;
        model[widx(a)] = d;
    endtask

    // driver: program one channel, push expected writes
    task automatic load_chan(int ch, logic [31:0] ctrl, logic [31:0] seed);
        put(tab_addr(ch, 0), ctrl);
        for (int k = 1; k < 4; k++) put(tab_addr(ch, k), seed ^ 32'(k * 32'h1111));
        for (int k = 0; k < 4; k++) put(tab_addr(ch, 4 + k), seed + 32'(k * 32'h0101_0203) + 32'h0000_ABCD);
        if (ctrl[3] && ctrl[1]) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] d;
                d = model[widx(tab_addr(ch, 4 + k))];
                if (k == 3) d[15:0] = 16'h0;   // R4 pointer base low half cleared
                exp_q.push_back({tab_addr(ch, k), d});
                model[widx(tab_addr(ch, k))] = d;
            end
        end
    endtask

    // trigger and check busy length and irq timing
    task automatic service(int ch, int exp_busy, bit exp_irq, bit ghost, string req);
        int n;
        bit irq_early;
        irq_early = 1'b0;
        chan_idx  = 3'(ch);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chan_idx  = 3'(ch + 1);
        n = 0;
        while (busy && n < 40) begin
            n++;
            if (irq) irq_early = 1'b1;
            if (ghost && n == 3) xfer_done = 1'b1;   // R8 pulse during service
            else xfer_done = 1'b0;
            @(negedge clk);
        end
        xfer_done = 1'b0;
        check(n == exp_busy, "R7 busy length", 64'(n), 64'(exp_busy));
        check(!irq_early, "R5 no irq while busy", 64'(irq_early), 64'h0);
        check(irq == exp_irq, {req, " irq after service"}, 64'(irq), 64'(exp_irq));
        @(negedge clk);
        check(!irq, "R5 irq one cycle", 64'(irq), 64'h0);
        check(!busy, "R8 no restart after ghost pulse", 64'(busy), 64'h0);
        check(exp_q.size() == 0, {req, " scoreboard drained"}, 64'(exp_q.size()), 64'h0);
        for (int k = 0; k < 8; k++) begin
            int i;
            i = widx(tab_addr(ch, k));
            check(ram[i] == model[i], {req, " RAM contents"}, 64'(ram[i]), 64'(model[i]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            ram[i] = '0;
            model[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !irq && !mem_req && !mem_we, "R9 reset outputs",
              {60'h0, busy, irq, mem_req, mem_we}, 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4: reload on channel 0
        load_chan(0, 32'h0000_000A, 32'h1234_5678);
        service(0, 10, 1'b0, 1'b0, "R3 ch0 reload");

        // R8: reload on channel 5 with a completion pulse while busy
        load_chan(5, 32'hFFFF_FF0A, 32'hCAFE_0001);
        service(5, 10, 1'b0, 1'b1, "R8 ch5 reload");

        // R5: reload disabled on channel 7 gives irq, table untouched
        load_chan(7, 32'h0000_0008, 32'h5555_AAAA);
        service(7, 2, 1'b1, 1'b0, "R5 ch7 irq");

        // R6: descriptor disabled on channel 2
        load_chan(2, 32'h0000_0002, 32'h0BAD_F00D);
        service(2, 2, 1'b0, 1'b0, "R6 ch2 disabled");

        // R2 R3: chained, reload brings a control word without reload, second completion interrupts
        load_chan(3, 32'h0000_000A, 32'h0000_0000);
        put(tab_addr(3, 4), 32'h0000_0008);
        begin
            logic [63:0] e;
            e = exp_q.pop_front();
            exp_q.push_front({tab_addr(3, 0), 32'h0000_0008});
            model[widx(tab_addr(3, 0))] = 32'h0000_0008;
            check(e[63:32] == tab_addr(3, 0), "R1 ch3 table address", e, 64'(tab_addr(3, 0)));
        end
        service(3, 10, 1'b0, 1'b0, "R2 ch3 reload");
        service(3, 2, 1'b1, 1'b0, "R5 ch3 after reload");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule